// File: doc/BRIEF.md
# Serial DDS Command Front End

This block is the control front end of a direct digital synthesizer. A host sends 16-bit command words over a three-wire serial link: an active-low frame strobe, a serial clock and a data line. Each word holds a 4-bit opcode, a 4-bit register address and an 8-bit payload. Writes to the wide registers are split in two. A staging command parks one byte. A later commit command joins that parked byte with its own payload, so a 16-bit frequency or phase register changes in a single step.

Each complete word crosses into the master-clock domain through a toggle handshake with a two-flop synchronizer. The word is then held back for a fixed number of master-clock cycles before it takes effect. The block drives two frequency tuning words, a bank of phase offset words, and the frequency and phase select controls. All of these feed a separate phase accumulator.

Top module: `dds_cmd_front`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the next outputs are all zero: both frequency words, every phase word, `freq_sel` and `phase_sel`. The staging byte is also cleared to zero.
- R2: A word is 16 bits, sent MSB first. One bit is sampled on each falling `sclk` edge while `fsync_n` is low. Bits [15:12] are the opcode, bits [11:8] the address and bits [7:0] the payload.
- R3: Opcode 1 stores the payload in the staging byte and leaves every output unchanged.
- R4: Opcode 2 writes {staging byte, payload} into frequency word 0 when the address is 0, and into frequency word 1 when the address is 1. Any other address is ignored.
- R5: Opcode 3 writes {staging byte, payload} into phase word N, where N is the address and N < NPH. An address of NPH or above is ignored. Phase word N occupies `phase_words[16*N+15:16*N]`.
- R6: Opcode 4 sets `freq_sel` to payload bit 0 and `phase_sel` to payload bits [2:1]. No other opcode changes the select outputs.
- R7: A commit does not clear the staging byte. Later commits reuse it until a new opcode 1 arrives.
- R8: If `fsync_n` rises before the 16th falling edge, the partial word is dropped and nothing changes. The next frame starts again from bit 15.
- R9: The effect of a word appears at the (LAT+3)th rising `clk` edge after its 16th falling `sclk` edge: two synchronizer stages, one detect stage, then LAT cycles. LAT is 6, or 8 when EXTRA_SYNC is set.
- R10: Opcodes other than 1 to 4 have no effect. Outputs never change without an accepted word.
- R11: Falling `sclk` edges while `fsync_n` is high are ignored and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset (master domain) |
| sclk | input | 1 | Serial clock, data sampled on falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdata | input | 1 | Serial data, MSB first |
| freq_word0 | output | 16 | Frequency tuning word 0 |
| freq_word1 | output | 16 | Frequency tuning word 1 |
| phase_words | output | 16*NPH | Packed phase offset words |
| freq_sel | output | 1 | Selects which frequency word drives the accumulator |
| phase_sel | output | clog2(NPH) | Selects which phase word is active |

## Verification
Each opcode is driven with payloads whose two halves differ, so a swapped byte order or a wrong bit order shows up at once. The staging byte is both reused and replaced, which separates a design that clears it on commit from one that keeps it. Truncated frames, clock edges sent with the strobe high, unknown opcodes and out-of-range addresses each test a different path by which a word could be wrongly accepted. A cycle-exact reference model catches any commit that lands one cycle early or late.

// File: rtl/dds_fe_pkg.sv
`timescale 1ns/1ps
package dds_fe_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int OPC_W  = 4;
  localparam int ADR_W  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_STAGE = 4'h1,
    OP_FREQ  = 4'h2,
    OP_PHASE = 4'h3,
    OP_SEL   = 4'h4
  } op_e;

  typedef struct packed {
    logic [OPC_W-1:0]  op;
    logic [ADR_W-1:0]  adr;
    logic [BYTE_W-1:0] pay;
  } cmd_word_t;
endpackage

// File: rtl/dds_fe_ser_rx.sv
`timescale 1ns/1ps
// Serial shifter: counts falling sclk edges inside a frame, emits a word and
// flips a toggle on the last bit.
module dds_fe_ser_rx #(
  parameter int W = 16
) (
  input  logic         sclk,
  input  logic         fsync_n,
  input  logic         sdata,
  output logic         tog,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;

  // Strobe high holds the counter at zero, so a short frame leaves no trace.
  always_ff @(negedge sclk or posedge fsync_n) begin
    if (fsync_n)               cnt <= '0;
    else if (cnt != CNT_FULL)  cnt <= cnt + 1'b1;
  end

  always_ff @(negedge sclk) begin
    if (cnt != CNT_FULL) begin
      sh <= {sh[W-3:0], sdata};
      if (cnt == CNT_LAST) begin
        word <= {sh, sdata};
        tog  <= ~tog;
      end
    end
  end

  always_ff @(negedge sclk) begin
    assert_cnt_bound_R2: assert (cnt <= CNT_FULL);
  end
endmodule

// File: rtl/dds_fe_cdc.sv
`timescale 1ns/1ps
// Toggle synchronizer plus a fixed-length delay line in the master domain.
module dds_fe_cdc #(
  parameter int W   = 16,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tog_in,
  input  logic [W-1:0] word_in,
  output logic         out_vld,
  output logic [W-1:0] out_word
);
  logic s1, s2, prev;
  logic ev;
  logic [LAT-1:0] vld;
  logic [W-1:0]   dat [LAT];

  // prev follows s2 even in reset, so a toggle left over from before reset
  // is absorbed instead of being seen as a new word.
  always_ff @(posedge clk) begin
    s1   <= tog_in;
    s2   <= s1;
    prev <= s2;
  end

  assign ev = (s2 != prev);

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], ev};
    dat[0] <= word_in;
    for (int k = 1; k < LAT; k++) dat[k] <= dat[k-1];
  end

  assign out_vld  = vld[LAT-1];
  assign out_word = dat[LAT-1];

  // A new word needs 16 serial edges, so detection is never two cycles long.
  assert_single_event_R9: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);
endmodule

// File: rtl/dds_fe_reg_bank.sv
`timescale 1ns/1ps
// Command decode and the registered output bank.
module dds_fe_reg_bank
  import dds_fe_pkg::*;
#(
  parameter int NPH = 4,
  localparam int PSW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply_vld,
  input  logic [WORD_W-1:0] apply_word,
  output logic [WORD_W-1:0] freq0,
  output logic [WORD_W-1:0] freq1,
  output logic [NPH*WORD_W-1:0] phase_flat,
  output logic              fsel,
  output logic [PSW-1:0]    psel
);
  cmd_word_t         cw;
  logic [BYTE_W-1:0] stage_q;
  logic [WORD_W-1:0] ph_q [NPH];

  assign cw = cmd_word_t'(apply_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      freq0   <= '0;
      freq1   <= '0;
      fsel    <= 1'b0;
      psel    <= '0;
      for (int k = 0; k < NPH; k++) ph_q[k] <= '0;
    end else if (apply_vld) begin
      case (cw.op)
        OP_STAGE: stage_q <= cw.pay;
        OP_FREQ: begin
          if (cw.adr == ADR_W'(0))      freq0 <= {stage_q, cw.pay};
          else if (cw.adr == ADR_W'(1)) freq1 <= {stage_q, cw.pay};
        end
        OP_PHASE: begin
          for (int k = 0; k < NPH; k++)
            if (cw.adr == ADR_W'(k)) ph_q[k] <= {stage_q, cw.pay};
        end
        OP_SEL: begin
          fsel <= cw.pay[0];
          psel <= cw.pay[PSW:1];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_flat
    assign phase_flat[g*WORD_W +: WORD_W] = ph_q[g];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (freq0 == '0 && freq1 == '0 && phase_flat == '0 && !fsel && psel == '0));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !apply_vld |=> ($stable(freq0) && $stable(freq1) && $stable(phase_flat)
                    && $stable(fsel) && $stable(psel)));

  assert_sel_only_by_op_R6: assert property (@(posedge clk) disable iff (rst)
    (apply_vld && cw.op != OP_SEL) |=> ($stable(fsel) && $stable(psel)));
endmodule

// File: rtl/dds_cmd_front.sv
`timescale 1ns/1ps
module dds_cmd_front
  import dds_fe_pkg::*;
#(
  parameter int NPH        = 4,
  parameter bit EXTRA_SYNC = 1'b0,
  localparam int PSW = (NPH > 1) ? $clog2(NPH) : 1,
  localparam int LAT = EXTRA_SYNC ? 8 : 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  fsync_n,
  input  logic                  sdata,
  output logic [WORD_W-1:0]     freq_word0,
  output logic [WORD_W-1:0]     freq_word1,
  output logic [NPH*WORD_W-1:0] phase_words,
  output logic                  freq_sel,
  output logic [PSW-1:0]        phase_sel
);
  logic              rx_tog;
  logic [WORD_W-1:0] rx_word;
  logic              ap_vld;
  logic [WORD_W-1:0] ap_word;

  dds_fe_ser_rx #(.W(WORD_W)) i_rx (
    .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
    .tog(rx_tog), .word(rx_word)
  );

  dds_fe_cdc #(.W(WORD_W), .LAT(LAT)) i_cdc (
    .clk(clk), .rst(rst), .tog_in(rx_tog), .word_in(rx_word),
    .out_vld(ap_vld), .out_word(ap_word)
  );

  dds_fe_reg_bank #(.NPH(NPH)) i_bank (
    .clk(clk), .rst(rst), .apply_vld(ap_vld), .apply_word(ap_word),
    .freq0(freq_word0), .freq1(freq_word1), .phase_flat(phase_words),
    .fsel(freq_sel), .psel(phase_sel)
  );
endmodule

// File: tb/test_dds_cmd_front.sv
`timescale 1ns/1ps
module test_dds_cmd_front;
  localparam int NPH = 4;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic fsync_n = 1'b1;
  logic sdata = 1'b0;
  logic [15:0] freq_word0, freq_word1;
  logic [NPH*16-1:0] phase_words;
  logic freq_sel;
  logic [1:0] phase_sel;

  dds_cmd_front #(.NPH(NPH), .EXTRA_SYNC(1'b0)) i_dds_cmd_front (
    .clk(clk), .rst(rst), .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
    .freq_word0(freq_word0), .freq_word1(freq_word1), .phase_words(phase_words),
    .freq_sel(freq_sel), .phase_sel(phase_sel)
  );

  always #4 clk = ~clk;  // 8 ns period

  int ncyc = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct { int due; logic [15:0] w; } pend_t;
  pend_t q[$];

  // Reference state
  logic [15:0] m_f0, m_f1, m_ph [NPH];
  logic [7:0]  m_stage;
  logic        m_fs;
  logic [1:0]  m_ps;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, ncyc);
    end
  endtask

  task automatic model_apply(input logic [15:0] w);
    int a;
    a = int'(w[11:8]);
    case (w[15:12])
      4'h1: m_stage = w[7:0];
      4'h2: begin
        if (a == 0) m_f0 = {m_stage, w[7:0]};
        else if (a == 1) m_f1 = {m_stage, w[7:0]};
      end
      4'h3: if (a < NPH) m_ph[a] = {m_stage, w[7:0]};
      4'h4: begin m_fs = w[0]; m_ps = w[2:1]; end
      default: ;
    endcase
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst) begin
      m_f0 = '0; m_f1 = '0; m_stage = '0; m_fs = 1'b0; m_ps = '0;
      for (int k = 0; k < NPH; k++) m_ph[k] = '0;
      q.delete();
    end else if (ncyc > 0) begin
      while (q.size() > 0 && q[0].due <= ncyc) model_apply(q.pop_front().w);
      chk("R9 R4 freq_word0", 64'(freq_word0), 64'(m_f0));
      chk("R9 R4 freq_word1", 64'(freq_word1), 64'(m_f1));
      chk("R9 R5 phase_words", phase_words, {m_ph[3], m_ph[2], m_ph[1], m_ph[0]});
      chk("R9 R6 selects", 64'({freq_sel, phase_sel}), 64'({m_fs, m_ps}));
    end
  end

  task automatic send(input logic [15:0] w, input int nb, output int fc);
    fc = -1;
    @(negedge clk); fsync_n = 1'b0;
    for (int i = 0; i < nb; i++) begin
      sdata = w[15-i];
      @(negedge clk); @(negedge clk); sclk = 1'b0;
      if (i == 15) begin
        fc = ncyc;
        q.push_back('{due: ncyc + 3 + LAT, w: w});
      end
      @(negedge clk); @(negedge clk); sclk = 1'b1;
    end
    @(negedge clk); fsync_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (LAT + 8) @(negedge clk);
  endtask

  function automatic logic [15:0] ph(input int n);
    return phase_words[n*16 +: 16];
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int fc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 freq0", 64'(freq_word0), 0);
    chk("R1 freq1", 64'(freq_word1), 0);
    chk("R1 phases", phase_words, 0);
    chk("R1 selects", 64'({freq_sel, phase_sel}), 0);

    // R3 staging only
    send(16'h1012, 16, fc); settle();
    chk("R3 outputs unchanged", {freq_word0, freq_word1, phase_words[31:0]}, 0);

    // R4 commit freq0, R7 reuse staging byte for freq1
    send(16'h2034, 16, fc); settle();
    chk("R4 freq0", 64'(freq_word0), 64'h1234);
    send(16'h2156, 16, fc); settle();
    chk("R7 freq1 reuses staging", 64'(freq_word1), 64'h1256);

    // R5 phase commit
    send(16'h10AB, 16, fc);
    send(16'h32CD, 16, fc); settle();
    chk("R5 phase2", 64'(ph(2)), 64'hABCD);
    chk("R5 other phases", 64'({ph(0), ph(1), ph(3)}), 0);

    // R6 select
    send(16'h4005, 16, fc); settle();
    chk("R6 freq_sel", 64'(freq_sel), 1);
    chk("R6 phase_sel", 64'(phase_sel), 2);

    // R8 truncated frame dropped, next frame fresh
    send(16'h20FF, 10, fc); settle();
    chk("R8 partial dropped", 64'(freq_word0), 64'h1234);
    send(16'h2077, 16, fc); settle();
    chk("R8 next frame", 64'(freq_word0), 64'hAB77);

    // R10 unknown opcodes and out-of-range addresses
    send(16'h70FF, 16, fc);
    send(16'h0F12, 16, fc);
    send(16'h2234, 16, fc);
    send(16'h3499, 16, fc); settle();
    chk("R10 freq0", 64'(freq_word0), 64'hAB77);
    chk("R10 freq1", 64'(freq_word1), 64'h1256);
    chk("R10 phases", phase_words, {16'h0, 16'hABCD, 16'h0, 16'h0});
    chk("R10 selects", 64'({freq_sel, phase_sel}), 64'({1'b1, 2'd2}));

    // R11 clock edges with strobe high
    for (int i = 0; i < 20; i++) begin
      sdata = i[0];
      @(negedge clk); sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
    end
    settle();
    chk("R11 no change", 64'(freq_word0), 64'hAB77);
    send(16'h2011, 16, fc); settle();
    chk("R11 frame after idle edges", 64'(freq_word0), 64'hAB11);

    // R2 bit order and field split
    send(16'h21A5, 16, fc); settle();
    chk("R2 msb first", 64'(freq_word1), 64'hABA5);

    // R9 exact latency
    send(16'h1055, 16, fc);
    send(16'h3080, 16, fc);
    while (ncyc != fc + 2 + LAT) @(negedge clk);
    chk("R9 before due", 64'(ph(0)), 0);
    @(negedge clk);
    chk("R9 at due", 64'(ph(0)), 64'h5580);

    settle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule